// File: doc/BRIEF.md
# Die PLL Programming Command Sequencer

This block drives the serial programming of the clock synthesizers on one hashing board that carries four dies. A single pulse on `start_i` makes it send twelve 32-bit write commands over an SPI master link, three per die. Each command holds a target register byte, the die number, and a two-byte value. For every die the pre-divider register (0x84) is written first, then the multiplier register (0x86), then the post-divider register (0x85). Dies are handled in ascending order, and all three writes to one die finish before the next die starts.

The two multiplier bytes come from `mul_hi_i` / `mul_lo_i`, so the clock can be tuned. A board in its normal setting uses 0x01 then 0xD1. The pre- and post-divider registers always get zero data. The SPI bit rate comes from `half_div_i`, which sets the number of system clocks in each SCLK half period. With a 50 MHz system clock, a value of 500 gives the usual 50 kHz, and 125 gives about 200 kHz. The multiplier bytes and the divider are captured when the sequence starts. When the last frame has been sent, `done_o` pulses for one cycle.

The controller has five states:
- ST_IDLE waits for start.
- ST_LOAD places the next frame into the shifter.
- ST_SHIFT has chip select low and clocks out 32 bits.
- ST_GAP has chip select high for one SCLK period.
- ST_DONE pulses done.

It has five transitions:
- start: ST_IDLE to ST_LOAD.
- load: ST_LOAD to ST_SHIFT.
- frame end: ST_SHIFT to ST_GAP.
- next frame: ST_GAP to ST_LOAD.
- last frame: ST_GAP to ST_DONE, then ST_DONE back to ST_IDLE.

Top module: `pll_cfg_seq`

## Requirements
- R1: Each frame is 32 bits, sent MSB first. The bytes, from first sent to last, are: register byte, die byte, data high byte, data low byte.
- R2: One sequence sends exactly 12 frames. Frame k has die byte k/3. Within a die, the register byte follows the order 0x84, 0x86, 0x85.
- R3: Frames to register 0x84 and register 0x85 carry data bytes 0x00, 0x00.
- R4: Frames to register 0x86 carry `mul_hi_i`, `mul_lo_i` as sampled on the start cycle. Later changes to these inputs do not alter any frame of that sequence.
- R5: The link uses SPI mode 0. SCLK is low whenever chip select is high. While chip select is low, MOSI changes only on a falling SCLK edge, and the first bit is valid before the first rising edge.
- R6: Chip select is low for exactly one frame, with 32 rising SCLK edges. Between frames it stays high for at least one SCLK period (2 x half period in clocks).
- R7: Each SCLK half period lasts `half_div_i` clocks, captured at start. A captured value of 0 acts as 1.
- R8: `done_o` is a one-cycle pulse. It comes after chip select is released at the end of the twelfth frame, and no further frames follow.
- R9: A start pulse while a sequence is running is ignored. It causes no extra frames and no extra done pulse.
- R10: After reset, `cs_n_o` is 1, `sclk_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a programming sequence (only acted on when idle) |
| half_div_i | input | DIV_W | System clocks per SCLK half period, captured at start |
| mul_hi_i | input | 8 | High data byte for the multiplier register |
| mul_lo_i | input | 8 | Low data byte for the multiplier register |
| sclk_o | output | 1 | SPI serial clock, idles low |
| mosi_o | output | 1 | SPI serial data out, MSB first |
| cs_n_o | output | 1 | Active-low chip select, one frame per assertion |
| done_o | output | 1 | One-cycle pulse after the last frame |

## Verification
A wrong die or slot counter appears at the ports within a single frame. The captured register or die byte of that frame no longer matches its position in the 12-frame order, and an early or missed end condition changes the frame count seen before `done_o`. A wrong bit counter or tick count shows up as a frame that is not 32 bits long, or a half period that differs from the captured divider, on the first affected frame. A shifter that updates on the wrong SCLK phase is caught on the first bit that moves while SCLK is high.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int FRAME_BITS = 32;

    localparam logic [7:0] REG_PRE  = 8'h84;
    localparam logic [7:0] REG_MUL  = 8'h86;
    localparam logic [7:0] REG_POST = 8'h85;

    localparam int SLOTS_PER_DIE = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/pll_seq_tick.sv
module pll_seq_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
        tick_o  = run_i && (cnt_q == div_eff - DIV_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pll_seq_frame.sv
module pll_seq_frame
    import pll_seq_pkg::*;
#(
    parameter int DIE_W = 2
) (
    input  logic [DIE_W-1:0]      die_i,
    input  logic [1:0]            slot_i,
    input  logic [7:0]            mul_hi_i,
    input  logic [7:0]            mul_lo_i,
    output logic [FRAME_BITS-1:0] frame_o
);
    logic [7:0] reg_byte;
    logic [7:0] die_byte;
    logic [15:0] data_word;

    always_comb begin
        die_byte  = 8'(die_i);
        reg_byte  = REG_PRE;
        data_word = 16'h0000;
        unique case (slot_i)
            2'd0: reg_byte = REG_PRE;
            2'd1: begin
                reg_byte  = REG_MUL;
                data_word = {mul_hi_i, mul_lo_i};
            end
            2'd2: reg_byte = REG_POST;
            default: reg_byte = REG_PRE;
        endcase
        frame_o = {reg_byte, die_byte, data_word};
    end

endmodule

// File: rtl/pll_seq_shifter.sv
module pll_seq_shifter #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  tick_i,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic                  fin_o
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [CNT_W-1:0]      bit_q;
    logic                  running_q;
    logic                  sclk_q;

    always_comb begin
        sclk_o = sclk_q;
        mosi_o = shreg_q[FRAME_BITS-1];
        fin_o  = running_q && tick_i && sclk_q && (bit_q == LAST_BIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_q     <= '0;
            running_q <= 1'b0;
            sclk_q    <= 1'b0;
        end else if (load_i) begin
            shreg_q   <= frame_i;
            bit_q     <= '0;
            running_q <= 1'b1;
            sclk_q    <= 1'b0;
        end else if (running_q && tick_i) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == LAST_BIT) begin
                    running_q <= 1'b0;
                end else begin
                    shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                    bit_q   <= bit_q + CNT_W'(1);
                end
            end
        end
    end

    // R5: data moves only together with a falling clock inside a frame
    assert_mosi_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && $past(running_q) && !$stable(mosi_o)) |-> $fell(sclk_q));

    // R5: serial clock is low whenever no frame is being shifted
    assert_sclk_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && $past(!running_q)) |-> !sclk_q);

endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
    import pll_seq_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int NUM_DIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] half_div_i,
    input  logic [7:0]       mul_hi_i,
    input  logic [7:0]       mul_lo_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             cs_n_o,
    output logic             done_o
);
    localparam int DIE_W = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1;
    localparam logic [DIE_W-1:0] LAST_DIE  = DIE_W'(NUM_DIES - 1);
    localparam logic [1:0]       LAST_SLOT = 2'(SLOTS_PER_DIE - 1);

    seq_state_t state_q, state_d;

    logic [DIE_W-1:0] die_q;
    logic [1:0]       slot_q;
    logic [7:0]       mul_hi_q, mul_lo_q;
    logic [DIV_W-1:0] div_q;
    logic             gap_half_q;
    logic             cs_n_q, done_q;

    logic                  tick;
    logic                  fin;
    logic                  last_frame;
    logic [FRAME_BITS-1:0] frame;

    assign last_frame = (die_q == LAST_DIE) && (slot_q == LAST_SLOT);

    pll_seq_tick #(.DIV_W(DIV_W)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  ((state_q == ST_SHIFT) || (state_q == ST_GAP)),
        .div_i  (div_q),
        .tick_o (tick)
    );

    pll_seq_frame #(.DIE_W(DIE_W)) frame_i (
        .die_i    (die_q),
        .slot_i   (slot_q),
        .mul_hi_i (mul_hi_q),
        .mul_lo_i (mul_lo_q),
        .frame_o  (frame)
    );

    pll_seq_shifter #(.FRAME_BITS(FRAME_BITS)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (state_q == ST_LOAD),
        .frame_i (frame),
        .tick_i  (tick),
        .sclk_o  (sclk_o),
        .mosi_o  (mosi_o),
        .fin_o   (fin)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (fin) state_d = ST_GAP;
            ST_GAP:   if (tick && gap_half_q) state_d = last_frame ? ST_DONE : ST_LOAD;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register together with the sequence counters and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            die_q      <= '0;
            slot_q     <= '0;
            mul_hi_q   <= '0;
            mul_lo_q   <= '0;
            div_q      <= '0;
            gap_half_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                die_q    <= '0;
                slot_q   <= '0;
                mul_hi_q <= mul_hi_i;
                mul_lo_q <= mul_lo_i;
                div_q    <= half_div_i;
            end
            if (state_q == ST_SHIFT) begin
                gap_half_q <= 1'b0;
            end else if (state_q == ST_GAP && tick) begin
                gap_half_q <= ~gap_half_q;
                if (gap_half_q && !last_frame) begin
                    if (slot_q == LAST_SLOT) begin
                        slot_q <= '0;
                        die_q  <= die_q + DIE_W'(1);
                    end else begin
                        slot_q <= slot_q + 2'd1;
                    end
                end
            end
        end
    end

    // registered outputs, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            cs_n_q <= (state_d != ST_SHIFT);
            done_q <= (state_d == ST_DONE);
        end
    end

    assign cs_n_o = cs_n_q;
    assign done_o = done_q;

    // R6: no clock activity while the chip is deselected
    assert_cs_high_sclk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    // R6: a release of chip select lasts more than one cycle
    assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |=> cs_n_o);

    // R8: completion is a single-cycle pulse with the chip deselected
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> cs_n_o);

    // R9: a start while shifting leaves the captured payload untouched
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && start_i) |=> ($stable(mul_hi_q) && $stable(mul_lo_q) && $stable(div_q)));

endmodule

// File: tb/pll_cfg_seq_tb.sv
module pll_cfg_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DIV_W-1:0] half_div_i = '0;
    logic [7:0]       mul_hi_i = 8'h00;
    logic [7:0]       mul_lo_i = 8'h00;
    logic             sclk_o, mosi_o, cs_n_o, done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_cfg_seq #(.DIV_W(DIV_W), .NUM_DIES(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_div_i(half_div_i),
        .mul_hi_i(mul_hi_i), .mul_lo_i(mul_lo_i),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .done_o(done_o)
    );

    // ---------------- port monitor (samples at falling clock edge) ----------
    logic [31:0] frames [0:31];
    int          fbits  [0:31];
    int          nframes, bitcnt, done_cnt, frames_at_done;
    int          gap_run, min_gap, hp_run, hp_min, hp_max, mode_viol;
    logic [31:0] cur;
    logic        have_edge;
    logic        p_sclk = 1'b0, p_cs_n = 1'b1, p_mosi = 1'b0;
    logic        mon_clr = 1'b0;

    always @(negedge clk) begin
        cycles++;
        if (mon_clr) begin
            nframes = 0; bitcnt = 0; done_cnt = 0; frames_at_done = -1;
            gap_run = 0; min_gap = 32'h7fff_ffff; hp_run = 0;
            hp_min = 32'h7fff_ffff; hp_max = 0; mode_viol = 0;
            cur = '0; have_edge = 1'b0;
        end else begin
            if (done_o) begin
                done_cnt++;
                frames_at_done = nframes;
            end
            if (cs_n_o && sclk_o) mode_viol++;
            if (!cs_n_o && !p_cs_n && (mosi_o != p_mosi) && !(p_sclk && !sclk_o)) mode_viol++;
            if (p_cs_n && !cs_n_o) begin
                if (nframes > 0 && gap_run < min_gap) min_gap = gap_run;
                bitcnt = 0; cur = '0; have_edge = 1'b0; hp_run = 0;
            end
            if (!cs_n_o) begin
                hp_run++;
                if (sclk_o != p_sclk) begin
                    if (have_edge) begin
                        if (hp_run < hp_min) hp_min = hp_run;
                        if (hp_run > hp_max) hp_max = hp_run;
                    end
                    have_edge = 1'b1;
                    hp_run = 0;
                end
                if (sclk_o && !p_sclk) begin
                    cur = {cur[30:0], mosi_o};
                    bitcnt++;
                end
            end
            if (!p_cs_n && cs_n_o) begin
                if (nframes < 32) begin
                    frames[nframes] = cur;
                    fbits[nframes]  = bitcnt;
                end
                nframes++;
                gap_run = 0;
            end
            if (cs_n_o) gap_run++;
        end
        p_sclk = sclk_o; p_cs_n = cs_n_o; p_mosi = mosi_o;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_frame(input int k, input logic [7:0] hi, input logic [7:0] lo);
        int slot = k % 3;
        logic [7:0] rb = (slot == 0) ? 8'h84 : (slot == 1) ? 8'h86 : 8'h85;
        logic [15:0] d = (slot == 1) ? {hi, lo} : 16'h0000;
        return {rb, 8'(k / 3), d};
    endfunction

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
    endtask

    task automatic check_run(input logic [7:0] hi, input logic [7:0] lo, input int hp, input string tag);
        chk(nframes == 12, "R2", {tag, " frame count"}, nframes, 12);
        for (int k = 0; k < 12 && k < nframes; k++) begin
            // R1 byte layout, R2 order, R3 zero data, R4 payload
            chk(frames[k] == exp_frame(k, hi, lo), ((k % 3) == 1) ? "R4" : "R1 R2 R3",
                {tag, " frame content"}, frames[k], exp_frame(k, hi, lo));
            chk(fbits[k] == 32, "R6", {tag, " rising edges per frame"}, fbits[k], 32);
        end
        chk(done_cnt == 1, "R8", {tag, " done pulses"}, done_cnt, 1);
        chk(frames_at_done == 12, "R8", {tag, " frames before done"}, frames_at_done, 12);
        chk(hp_min == hp && hp_max == hp, "R7", {tag, " half period"}, hp_max, hp);
        chk(min_gap >= 2 * hp, "R6", {tag, " deselect gap"}, min_gap, 2 * hp);
        chk(mode_viol == 0, "R5", {tag, " mode 0 data timing"}, mode_viol, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic test_reset();
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R10", "cs_n after reset", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R10", "sclk after reset", sclk_o, 0);
        chk(done_o == 1'b0, "R10", "done after reset", done_o, 0);
    endtask

    task automatic test_default_payload();
        mul_hi_i = 8'h01; mul_lo_i = 8'hD1; half_div_i = 16'd3;
        clear_mon(); pulse_start(); wait_done(20000);
        repeat (40) @(negedge clk);
        check_run(8'h01, 8'hD1, 3, "default");
    endtask

    task automatic test_tuned_payload();
        mul_hi_i = 8'h5A; mul_lo_i = 8'hC3; half_div_i = 16'd1;
        clear_mon(); pulse_start(); wait_done(20000);
        repeat (20) @(negedge clk);
        check_run(8'h5A, 8'hC3, 1, "tuned");
    endtask

    task automatic test_latch_midseq();
        mul_hi_i = 8'hAB; mul_lo_i = 8'h12; half_div_i = 16'd2;
        clear_mon(); pulse_start();
        repeat (50) @(negedge clk);
        mul_hi_i = 8'hFF; mul_lo_i = 8'hFF; half_div_i = 16'd5; // r4_ r7_ must not take effect
        wait_done(20000);
        repeat (40) @(negedge clk);
        check_run(8'hAB, 8'h12, 2, "latched");
    endtask

    task automatic test_busy_start();
        mul_hi_i = 8'h33; mul_lo_i = 8'h44; half_div_i = 16'd2;
        clear_mon(); pulse_start();
        repeat (300) @(negedge clk);
        mul_hi_i = 8'h99; mul_lo_i = 8'h88;
        pulse_start(); // R9: ignored while busy
        wait_done(20000);
        repeat (400) @(negedge clk);
        check_run(8'h33, 8'h44, 2, "busy start");
        chk(cs_n_o == 1'b1, "R9", "idle after sequence", cs_n_o, 1);
    endtask

    task automatic test_div_zero();
        mul_hi_i = 8'h01; mul_lo_i = 8'hD1; half_div_i = 16'd0;
        clear_mon(); pulse_start(); wait_done(20000);
        repeat (20) @(negedge clk);
        check_run(8'h01, 8'hD1, 1, "div zero");
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        mon_clr = 1'b1;
        repeat (3) @(negedge clk);
        mon_clr = 1'b0;
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_default_payload();
        test_tuned_payload();
        test_latch_midseq();
        test_busy_start();
        test_div_zero();
        finish_run();
    end

    initial begin
        wait (cycles > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
    end

endmodule